// File: doc/BRIEF.md
# Stereo Audio Port Register File

This block is the register file of a stereo serial audio port. It sits on a simple single-beat read/write bus and uses 32-bit word addressing with a 4-byte stride. It holds the port's control state: the transmit and receive enables, the bit-clock divider and the per-channel word length. It also drives one-cycle reset and flush strobes into the serial audio engine.

Two 32-bit sample FIFOs live inside the block. Software pushes transmit samples through a fixed write window, and the engine drains them. The engine fills the receive FIFO, and software drains it through a fixed read window. A status word reports the fill state of both FIFOs and a sticky transmit-overflow flag.

Reset is write-triggered. A single write can fire a global reset, a transmit flush and a receive flush in any combination. Read data is registered and arrives one cycle after the request.

Top module: `aud_port_regs`

## Requirements
- R1: After reset the controls read 0, the clock word holds its default (divider 3, word length field 31 → 0x001F0003), no strobe is active, and status reads 0x0000000A.
- R2: Control word at byte offset 0x04. Bit 0 drives `tx_enable` and bit 1 drives `rx_enable`. Each bit is written independently and reads back, and all other bits read 0.
- R3: Clock word at offset 0x08. Bits 15:0 drive `bclk_div`. Bits 16+WS_W-1..16 drive `word_len_m1`. Higher bits are dropped and read 0.
- R4: A write to offset 0x00 fires the strobes for the bits that are set. Bit 0 fires `glob_rst_pulse`, bit 1 fires `tx_flush_pulse` and bit 2 fires `rx_flush_pulse`. Each strobe is high for exactly the cycle after the write. Offset 0x00 always reads 0.
- R5: A global reset clears both FIFOs, both enables and the overflow flag. It also restores the clock word to its default. All of this is visible from the cycle after the write.
- R6: A write to offset 0x2C pushes one sample into the transmit FIFO. The engine sees the samples in push order on `eng_tx_data` while `eng_tx_avail` is high, and `eng_tx_pop` advances to the next one.
- R7: A write to offset 0x2C while the transmit FIFO is full is dropped and sets the sticky overflow flag. Only a transmit flush or a global reset clears that flag.
- R8: A read from offset 0x28 pops the receive FIFO and returns the samples in arrival order. A read while the FIFO is empty returns 0.
- R9: Status word at offset 0x10 has these bits: bit 0 transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty, bit 4 transmit overflow. All other bits are 0.
- R10: An engine push while the receive FIFO is full is dropped, and the stored samples are kept.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read request. Unmapped offsets, and the transmit window when read, return 0. Writes to unmapped offsets change nothing.
- R12: A transmit flush empties only the transmit FIFO, and a receive flush empties only the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| tx_enable | output | 1 | Transmit enable to engine |
| rx_enable | output | 1 | Receive enable to engine |
| bclk_div | output | 16 | Bit-clock divider |
| word_len_m1 | output | WS_W | Word length per channel minus one |
| glob_rst_pulse | output | 1 | One-cycle global reset strobe |
| tx_flush_pulse | output | 1 | One-cycle transmit flush strobe |
| rx_flush_pulse | output | 1 | One-cycle receive flush strobe |
| eng_tx_data | output | 32 | Oldest transmit sample |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_tx_pop | input | 1 | Engine consumes one transmit sample |
| eng_rx_data | input | 32 | Sample from engine |
| eng_rx_push | input | 1 | Engine delivers one receive sample |

## Verification
The bench builds the block with its defaults: ADDR_W 6, FIFO_DEPTH 4, WS_W 5, divider default 3 and word-length default 31. With a depth of 4, both full flags, the dropped fifth transmit write and the dropped fifth engine push are reached in a handful of cycles. A 5-bit word-length field lets an all-ones write show the truncation of the upper clock-word bits as 0x001FABCD. The fixed defaults give a known clock word to compare against after a global reset.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RST, SEL_CTRL, SEL_CLK, SEL_STAT, SEL_RXWIN, SEL_TXWIN
  } reg_sel_e;

  // word index = byte address / 4
  function automatic reg_sel_e decode_word(input logic [7:0] widx);
    case (widx)
      8'd0:    return SEL_RST;
      8'd1:    return SEL_CTRL;
      8'd2:    return SEL_CLK;
      8'd4:    return SEL_STAT;
      8'd10:   return SEL_RXWIN;
      8'd11:   return SEL_TXWIN;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
    input logic tx_full, input logic tx_empty,
    input logic rx_full, input logic rx_empty, input logic tx_ovf);
    return {27'd0, tx_ovf, rx_empty, rx_full, tx_empty, tx_full};
  endfunction
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/aud_port_regs.sv
module aud_port_regs
  import aud_port_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int WS_W       = 5,
  parameter int DIV_DEF    = 3,
  parameter int WS_DEF     = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic [15:0]       bclk_div,
  output logic [WS_W-1:0]   word_len_m1,
  output logic              glob_rst_pulse,
  output logic              tx_flush_pulse,
  output logic              rx_flush_pulse,
  output logic [31:0]       eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_tx_pop,
  input  logic [31:0]       eng_rx_data,
  input  logic              eng_rx_push
);
  localparam logic [15:0]     DIV_RST = 16'(DIV_DEF);
  localparam logic [WS_W-1:0] WS_RST  = WS_W'(WS_DEF);
  localparam int              PAD_W   = 16 - WS_W;

  reg_sel_e    sel;
  logic        wr, rd;
  logic        glob_hit, txfl_hit, rxfl_hit;
  logic        tx_push_try, tx_drop, rx_pop_try, rx_empty_rd;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        tx_ovf;
  logic [31:0] rx_head, rd_mux;

  assign sel = decode_word(8'(bus_addr >> 2));
  assign wr  = bus_valid && bus_write;
  assign rd  = bus_valid && !bus_write;

  // named events
  assign glob_hit    = wr && (sel == SEL_RST) && bus_wdata[0];
  assign txfl_hit    = glob_hit || (wr && (sel == SEL_RST) && bus_wdata[1]);
  assign rxfl_hit    = glob_hit || (wr && (sel == SEL_RST) && bus_wdata[2]);
  assign tx_push_try = wr && (sel == SEL_TXWIN);
  assign tx_drop     = tx_push_try && tx_full;
  assign rx_pop_try  = rd && (sel == SEL_RXWIN);
  assign rx_empty_rd = rx_pop_try && rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_enable   <= 1'b0;
      rx_enable   <= 1'b0;
      bclk_div    <= DIV_RST;
      word_len_m1 <= WS_RST;
    end else if (glob_hit) begin
      tx_enable   <= 1'b0;
      rx_enable   <= 1'b0;
      bclk_div    <= DIV_RST;
      word_len_m1 <= WS_RST;
    end else begin
      if (wr && sel == SEL_CTRL) begin
        tx_enable <= bus_wdata[0];
        rx_enable <= bus_wdata[1];
      end
      if (wr && sel == SEL_CLK) begin
        bclk_div    <= bus_wdata[15:0];
        word_len_m1 <= bus_wdata[16 +: WS_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || txfl_hit) tx_ovf <= 1'b0;
    else if (tx_drop)       tx_ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_rst_pulse <= 1'b0;
      tx_flush_pulse <= 1'b0;
      rx_flush_pulse <= 1'b0;
    end else begin
      glob_rst_pulse <= glob_hit;
      tx_flush_pulse <= wr && (sel == SEL_RST) && bus_wdata[1];
      rx_flush_pulse <= wr && (sel == SEL_RST) && bus_wdata[2];
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_mux = {30'd0, rx_enable, tx_enable};
      SEL_CLK:   rd_mux = {{PAD_W{1'b0}}, word_len_m1, bclk_div};
      SEL_STAT:  rd_mux = pack_status(tx_full, tx_empty, rx_full, rx_empty, tx_ovf);
      SEL_RXWIN: rd_mux = rx_empty ? 32'd0 : rx_head;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= 32'd0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  aud_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(txfl_hit),
    .push(tx_push_try), .wdata(bus_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .full(tx_full), .empty(tx_empty)
  );

  aud_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rxfl_hit),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_pop_try), .rdata(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_avail = !tx_empty;
endmodule

// File: rtl/aud_port_chk.sv
module aud_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              glob_rst_pulse,
  input logic              tx_enable,
  input logic              rx_enable,
  input logic              eng_tx_avail,
  input logic              tx_drop,
  input logic              tx_ovf,
  input logic              rx_empty_rd,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_empty
);
  // R5
  glob_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && (bus_addr >> 2) == '0 && bus_wdata[0])
    |=> (glob_rst_pulse && !tx_enable && !rx_enable && !eng_tx_avail));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> tx_ovf);

  // R8
  rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty_rd |=> (bus_rvalid && bus_rdata == 32'd0));

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  // R11
  rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

bind aud_port_regs aud_port_chk #(.ADDR_W(ADDR_W)) u_aud_port_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .glob_rst_pulse(glob_rst_pulse),
  .tx_enable(tx_enable), .rx_enable(rx_enable), .eng_tx_avail(eng_tx_avail),
  .tx_drop(tx_drop), .tx_ovf(tx_ovf), .rx_empty_rd(rx_empty_rd),
  .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty)
);

// File: tb/tb_aud_port_regs.sv
module tb_aud_port_regs;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 4;
  localparam int WS_W   = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, tx_enable, rx_enable;
  logic [15:0] bclk_div;
  logic [WS_W-1:0] word_len_m1;
  logic glob_rst_pulse, tx_flush_pulse, rx_flush_pulse;
  logic [31:0] eng_tx_data;
  logic eng_tx_avail;
  logic eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [31:0] eng_rx_data = '0;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aud_port_regs #(.ADDR_W(ADDR_W), .FIFO_DEPTH(DEPTH), .WS_W(WS_W)) dut (.*);

  localparam logic [ADDR_W-1:0] A_RST = 6'h00, A_CTRL = 6'h04, A_CLK = 6'h08,
    A_STAT = 6'h10, A_RXW = 6'h28, A_TXW = 6'h2C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic brd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    total++;
    if (bus_rvalid !== 1'b1) begin
      bad++; $display("FAIL R11: rvalid actual=%b expected=1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic epush(input logic [31:0] d);
    eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  task automatic epop(output logic [31:0] d);
    d = eng_tx_data; eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tx_enable", 32'(tx_enable), 0);
    chk("R1 rx_enable", 32'(rx_enable), 0);
    chk("R1 bclk_div", 32'(bclk_div), 3);
    chk("R1 word_len", 32'(word_len_m1), 31);
    chk("R1 pulses", 32'({glob_rst_pulse, tx_flush_pulse, rx_flush_pulse}), 0);
    brd(A_STAT, v); chk("R1 status", v, 32'h0000000A);
    brd(A_CLK, v);  chk("R1 clk word", v, 32'h001F0003);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    bwr(A_CTRL, 32'h1); chk("R2 tx only", 32'({rx_enable, tx_enable}), 32'h1);
    bwr(A_CTRL, 32'h2); chk("R2 rx only", 32'({rx_enable, tx_enable}), 32'h2);
    bwr(A_CTRL, 32'h3); brd(A_CTRL, v); chk("R2 both readback", v, 32'h3);
    bwr(A_CTRL, 32'hFFFF_FFFC); brd(A_CTRL, v); chk("R2 upper ignored", v, 32'h0);
  endtask

  task automatic t_clk();
    logic [31:0] v;
    bwr(A_CLK, 32'h0007_1234); brd(A_CLK, v);
    chk("R3 readback", v, 32'h0007_1234);
    chk("R3 div out", 32'(bclk_div), 32'h1234);
    chk("R3 ws out", 32'(word_len_m1), 7);
    bwr(A_CLK, 32'hFFFF_ABCD); brd(A_CLK, v);
    chk("R3 truncated", v, 32'h001F_ABCD);
  endtask

  task automatic t_tx();
    logic [31:0] v;
    bwr(A_TXW, 32'hA1); bwr(A_TXW, 32'hA2); bwr(A_TXW, 32'hA3);
    chk("R6 avail", 32'(eng_tx_avail), 1);
    brd(A_STAT, v); chk("R9 tx partial", v, 32'h8);
    epop(v); chk("R6 order 1", v, 32'hA1);
    epop(v); chk("R6 order 2", v, 32'hA2);
    epop(v); chk("R6 order 3", v, 32'hA3);
    chk("R6 drained", 32'(eng_tx_avail), 0);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) bwr(A_TXW, 32'hB0 + 32'(i));
    brd(A_STAT, v); chk("R9 tx full", v, 32'h9);
    bwr(A_TXW, 32'hDEAD);
    brd(A_STAT, v); chk("R7 ovf set", v, 32'h19);
    epop(v); chk("R7 sticky after pop", 32'(v), 32'hB0);
    brd(A_STAT, v); chk("R7 still set", v, 32'h18);
    for (int i = 1; i < DEPTH; i++) begin
      epop(v); chk("R7 kept data", v, 32'hB0 + 32'(i));
    end
    chk("R7 drop not stored", 32'(eng_tx_avail), 0);
    bwr(A_RST, 32'h2);
    brd(A_STAT, v); chk("R7 cleared by flush", v, 32'hA);
  endtask

  task automatic t_rx();
    logic [31:0] v;
    epush(32'hC1); epush(32'hC2);
    brd(A_RXW, v); chk("R8 first", v, 32'hC1);
    brd(A_RXW, v); chk("R8 second", v, 32'hC2);
    brd(A_RXW, v); chk("R8 empty zero", v, 32'h0);
    for (int i = 0; i < DEPTH; i++) epush(32'hD0 + 32'(i));
    epush(32'hBEEF);
    brd(A_STAT, v); chk("R10 rx full", v, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      brd(A_RXW, v); chk("R10 kept", v, 32'hD0 + 32'(i));
    end
    brd(A_RXW, v); chk("R10 drop not stored", v, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] v;
    bwr(A_TXW, 32'h11); epush(32'h22);
    bwr(A_RST, 32'h2);
    chk("R4 tx strobe", 32'({glob_rst_pulse, tx_flush_pulse, rx_flush_pulse}), 32'h2);
    @(negedge clk);
    chk("R4 strobe one cycle", 32'(tx_flush_pulse), 0);
    brd(A_STAT, v); chk("R12 only tx flushed", v, 32'h2);
    brd(A_RST, v); chk("R4 reads zero", v, 32'h0);
    bwr(A_TXW, 32'h33);
    bwr(A_RST, 32'h4);
    chk("R4 rx strobe", 32'({glob_rst_pulse, tx_flush_pulse, rx_flush_pulse}), 32'h1);
    brd(A_STAT, v); chk("R12 only rx flushed", v, 32'h8);
    epop(v); chk("R12 tx kept", v, 32'h33);
  endtask

  task automatic t_glob();
    logic [31:0] v;
    bwr(A_CTRL, 32'h3); bwr(A_CLK, 32'h0005_0042);
    for (int i = 0; i <= DEPTH; i++) bwr(A_TXW, 32'(i));
    epush(32'h77);
    bwr(A_RST, 32'h1);
    chk("R4 glob strobe", 32'({glob_rst_pulse, tx_flush_pulse, rx_flush_pulse}), 32'h4);
    chk("R5 enables off", 32'({rx_enable, tx_enable}), 0);
    brd(A_CLK, v);  chk("R5 clk default", v, 32'h001F0003);
    brd(A_STAT, v); chk("R5 fifos and ovf clear", v, 32'hA);
    chk("R4 glob strobe gone", 32'(glob_rst_pulse), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bwr(A_CTRL, 32'h1);
    bwr(6'h0C, 32'hFFFF_FFFF); bwr(6'h14, 32'hFFFF_FFFF); bwr(A_RXW, 32'h55);
    brd(A_CTRL, v); chk("R11 ctrl untouched", v, 32'h1);
    brd(A_STAT, v); chk("R11 rx win write ignored", v, 32'hA);
    brd(6'h0C, v);  chk("R11 unmapped reads 0", v, 32'h0);
    bwr(A_TXW, 32'h99);
    brd(A_TXW, v);  chk("R11 tx win reads 0", v, 32'h0);
    @(negedge clk);
    chk("R11 rvalid drops", 32'(bus_rvalid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_ctrl(); t_clk(); t_tx(); t_ovf(); t_rx(); t_flush(); t_glob(); t_unmapped();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule